// File: doc/BRIEF.md
# Multi-Mode Host Bus Interface

This block is the slave side of an 8-bit processor bus that sits in front of a small register file. Two static selection pins choose the bus style. One pin picks either separate read and write strobes or a single data strobe with a read/write direction line. The other pin picks either a dedicated 5-bit address bus or a shared 8-bit address/data bus. In shared-bus operation, an address strobe loads the address from the bus. The host's control strobes are synchronized into a reference clock domain. A wait-state generator in that domain counts a fixed number of reference cycles before it reports completion on a single combined handshake output. The meaning of that output depends on the selected style.

In separate-strobe style, the handshake works as a ready line. It is low while the host must insert wait states and high when the cycle may end. In data-strobe style, it works as an acknowledge line. It goes low once read data is valid or write data has been taken, and it stays low until the strobe is released. A write to the soft-reset register clears the configuration. In separate-strobe, dedicated-address style, that write never pulls the ready line low. An active-low interrupt output reports sticky alarm bits that are masked by an enable register.

Top module: `hostbus_if`

## Requirements
- R1: After reset, `hs` is 1, `irq_n` is 1, `data_oe` is 0, and every address reads back 0x00.
- R2: In every mode, a storage register (any address below 18 except 0x00 and 0x0A) reads back the last value written to it.
- R3: With `sel_demux`=0, the access address is the low 5 bits of `data_in`, captured on the falling edge of `ale`. `addr_in` and `data_in[7:5]` are ignored. With `sel_demux`=1, `addr_in` supplies the address.
- R4: With `sel_moto`=0, an access is requested by `cs_n`=0 together with `rd_n`=0 (read) or `wr_n`=0 (write). `hs` is then 0 for exactly WAIT_CYC reference cycles before it returns to 1. Once `hs` has returned to 1, a read drives `data_out` with `data_oe`=1.
- R5: With `sel_moto`=1, an access is requested by `cs_n`=0 and `ds_n`=0, with `rw`=1 for read and 0 for write. `hs` goes to 0 when the access completes, and a read then has valid `data_out` and `data_oe`=1. `hs` returns to 1 after the strobe is released.
- R6: While `cs_n` is 1, `hs` is 1, and strobe activity writes nothing.
- R7: With `sel_moto`=0 and `sel_demux`=1, a write to address 0x0A keeps `hs` at 1 for the whole access.
- R8: Addresses 0x12 to 0x1F read as 0x00, and writes to them change nothing.
- R9: Address 0x00 holds sticky alarm status. A bit is set while the matching `alarm_in` bit is 1, whatever the enable. Writing a 1 clears that bit unless the alarm is still present, in which case the set wins.
- R10: Address 0x01 is the alarm enable register. `irq_n` is 0 exactly when some status bit and its matching enable bit are both 1.
- R11: A write to 0x0A, in any mode, clears every register to 0x00. Address 0x0A itself always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refclk | input | 1 | Reference clock for synchronizers and wait-state counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_demux | input | 1 | 1: dedicated address bus, 0: shared address/data bus |
| sel_moto | input | 1 | 1: data strobe plus direction, 0: separate read/write strobes |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low (separate-strobe style) |
| wr_n | input | 1 | Write strobe, active low (separate-strobe style) |
| ds_n | input | 1 | Data strobe, active low (data-strobe style) |
| rw | input | 1 | Direction, 1 read / 0 write (data-strobe style) |
| ale | input | 1 | Address strobe; address captured on its falling edge |
| addr_in | input | AW | Dedicated address bus |
| data_in | input | DW | Write data, or address during the address phase in shared-bus mode |
| alarm_in | input | DW | Alarm conditions from the line functions |
| data_out | output | DW | Read data |
| data_oe | output | 1 | Read data valid, pad enable |
| hs | output | 1 | Ready / acknowledge handshake |
| irq_n | output | 1 | Interrupt, active low |

## Verification
All 32 addresses are swept with a write pass and then a read pass in each of the four modes, using a data value derived from the address and the mode. This separates storage registers, the write-one-to-clear status register, the soft-reset register and the unmapped space. In shared-bus modes, the dedicated address pins carry the inverted address and the upper bus bits carry junk during the address phase, so an address taken from the wrong source shows up as a data mismatch. The number of low handshake cycles per access tells the counted wait of the ready style apart from the acknowledge style and from the soft-reset exception. Separate alarm sequences check that status bits stick, that the set wins over a clear while the alarm is present, and that the interrupt is masked.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int ADDR_STAT  = 0;
  localparam int ADDR_IRQEN = 1;
  localparam int ADDR_SWRST = 10;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_DONE = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
          stg_q[0] <= d;
          for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hbi_hshake.sv
module hbi_hshake
  import hbi_pkg::*;
#(
  parameter int AW       = 5,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          moto,
  input  logic          demux,
  input  logic          cs_act,
  input  logic          strb_act,
  input  logic          rd_req,
  input  logic [AW-1:0] addr,
  output logic          hs,
  output logic          fire,
  output logic          acc_rd,
  output logic          done
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CYC - 1);

  hs_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_q, rd_d;
  logic          rstw_q, rstw_d;
  logic          req;

  assign req = cs_act && strb_act;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    rstw_d  = rstw_q;
    fire    = 1'b0;
    case (state_q)
      HS_IDLE: begin
        if (req) begin
          state_d = HS_WAIT;
          cnt_d   = '0;
          rd_d    = rd_req;
          rstw_d  = !moto && demux && !rd_req && (addr == AW'(ADDR_SWRST));
        end
      end
      HS_WAIT: begin
        if (!req) begin
          state_d = HS_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          state_d = HS_DONE;
          fire    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      HS_DONE: begin
        if (!req) state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      rstw_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      rstw_q  <= rstw_d;
    end
  end

  always_comb begin
    if (!cs_act)   hs = 1'b1;
    else if (moto) hs = (state_q != HS_DONE);
    else           hs = !((state_q == HS_WAIT) && !rstw_q);
  end

  assign acc_rd = rd_q;
  assign done   = (state_q == HS_DONE);

  // R4
  wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_DONE && $past(state_q) == HS_WAIT) |-> ($past(cnt_q) == CNT_LAST));

  // R7
  rst_wr_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rstw_q && state_q != HS_IDLE) |-> hs);
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs
  import hbi_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 5,
  parameter int NREG = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic          rd_fire,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] alarm,
  output logic [DW-1:0] rdata,
  output logic          irq_n
);
  logic [DW-1:0] reg_q [NREG];
  logic [DW-1:0] reg_d [NREG];
  logic [DW-1:0] rdata_q, rdata_d, rd_val;
  logic          irq_q, irq_d;
  logic          soft_rst;

  assign soft_rst = wr_fire && (addr == AW'(ADDR_SWRST));

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      if (i == ADDR_STAT) begin
        if (soft_rst)
          reg_d[i] = alarm;
        else if (wr_fire && addr == AW'(i))
          reg_d[i] = (reg_q[i] & ~wdata) | alarm;
        else
          reg_d[i] = reg_q[i] | alarm;
      end else if (i == ADDR_SWRST || soft_rst) begin
        reg_d[i] = '0;
      end else if (wr_fire && addr == AW'(i)) begin
        reg_d[i] = wdata;
      end else begin
        reg_d[i] = reg_q[i];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == AW'(i) && i != ADDR_SWRST) rd_val = reg_q[i];
    end
    rdata_d = rd_fire ? rd_val : rdata_q;
    irq_d   = ~|(reg_q[ADDR_STAT] & reg_q[ADDR_IRQEN]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b1;
    end else begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= reg_d[i];
      rdata_q <= rdata_d;
      irq_q   <= irq_d;
    end
  end

  assign rdata = rdata_q;
  assign irq_n = irq_q;

  // R9
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|alarm) |=> ((reg_q[ADDR_STAT] & $past(alarm)) == $past(alarm)));

  // R8
  unimpl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && addr >= AW'(NREG)) |=> (rdata == '0));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(reg_q[ADDR_STAT] & reg_q[ADDR_IRQEN])) |=> !irq_n);
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if #(
  parameter int DW          = 8,
  parameter int AW          = 5,
  parameter int NREG        = 18,
  parameter int WAIT_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          refclk,
  input  logic          rst_n,
  input  logic          sel_demux,
  input  logic          sel_moto,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ds_n,
  input  logic          rw,
  input  logic          ale,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] alarm_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          hs,
  output logic          irq_n
);
  localparam int NCTL = 5;

  logic [1:0]      rst_pipe_q;
  logic            rst_n_s;
  logic [NCTL-1:0] ctl_s;
  logic [DW-1:0]   alarm_s;
  logic            cs_s, rd_s, wr_s, ds_s, ale_s;
  logic            ale_prev_q;
  logic [AW-1:0]   lat_addr_q, lat_addr_d;
  logic [AW-1:0]   addr_eff;
  logic            cs_act, strb_act, rd_req;
  logic            fire, acc_rd, done;

  always_ff @(posedge refclk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  hbi_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(5'b11110)) u_ctl_sync (
    .clk(refclk), .rst_n(rst_n_s),
    .d({cs_n, rd_n, wr_n, ds_n, ale}), .q(ctl_s)
  );

  hbi_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_alm_sync (
    .clk(refclk), .rst_n(rst_n_s), .d(alarm_in), .q(alarm_s)
  );

  assign {cs_s, rd_s, wr_s, ds_s, ale_s} = ctl_s;

  always_comb begin
    lat_addr_d = lat_addr_q;
    if (!sel_demux && ale_prev_q && !ale_s) lat_addr_d = data_in[AW-1:0];
  end

  always_ff @(posedge refclk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ale_prev_q <= 1'b0;
      lat_addr_q <= '0;
    end else begin
      ale_prev_q <= ale_s;
      lat_addr_q <= lat_addr_d;
    end
  end

  assign addr_eff = sel_demux ? addr_in : lat_addr_q;
  assign cs_act   = !cs_s;
  assign strb_act = sel_moto ? !ds_s : (!rd_s || !wr_s);
  assign rd_req   = sel_moto ? rw : !rd_s;

  hbi_hshake #(.AW(AW), .WAIT_CYC(WAIT_CYC)) u_hshake (
    .clk(refclk), .rst_n(rst_n_s), .moto(sel_moto), .demux(sel_demux),
    .cs_act(cs_act), .strb_act(strb_act), .rd_req(rd_req), .addr(addr_eff),
    .hs(hs), .fire(fire), .acc_rd(acc_rd), .done(done)
  );

  hbi_regs #(.DW(DW), .AW(AW), .NREG(NREG)) u_regs (
    .clk(refclk), .rst_n(rst_n_s),
    .wr_fire(fire && !acc_rd), .rd_fire(fire && acc_rd),
    .addr(addr_eff), .wdata(data_in), .alarm(alarm_s),
    .rdata(data_out), .irq_n(irq_n)
  );

  assign data_oe = cs_act && done && acc_rd;

  // R5
  moto_oe_chk: assert property (@(posedge refclk) disable iff (!rst_n_s)
    (sel_moto && !hs && acc_rd) |-> data_oe);

  // R6
  cs_idle_hs_chk: assert property (@(posedge refclk) disable iff (!rst_n_s)
    (!cs_act && !$past(cs_act)) |-> (hs && !data_oe));
endmodule

// File: tb/hostbus_if_bench.sv
module hostbus_if_bench;
  localparam int WAIT_CYC = 2;

  logic       refclk = 1'b0;
  logic       rst_n;
  logic       sel_demux, sel_moto;
  logic       cs_n, rd_n, wr_n, ds_n, rw, ale;
  logic [4:0] addr_in;
  logic [7:0] data_in, alarm_in;
  logic [7:0] data_out;
  logic       data_oe, hs, irq_n;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q [32];
  logic       last_oe;

  always #10 refclk = ~refclk;

  hostbus_if #(.WAIT_CYC(WAIT_CYC)) u_hostbus_if (
    .refclk(refclk), .rst_n(rst_n), .sel_demux(sel_demux), .sel_moto(sel_moto),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n), .rw(rw), .ale(ale),
    .addr_in(addr_in), .data_in(data_in), .alarm_in(alarm_in),
    .data_out(data_out), .data_oe(data_oe), .hs(hs), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_wr(input int a, input logic [7:0] d);
    if (a == 10) begin
      for (int i = 0; i < 32; i++) exp_q[i] = 8'h00;
    end else if (a == 0) begin
      exp_q[0] = exp_q[0] & ~d;
    end else if (a < 18) begin
      exp_q[a] = d;
    end
  endtask

  task automatic access(input bit is_rd, input int a, input logic [7:0] d,
                        output logic [7:0] rv, output int low_cnt);
    low_cnt = 0;
    if (!sel_demux) begin
      data_in = {3'b101, 5'(a)};
      addr_in = ~5'(a);
      ale = 1'b1;
      repeat (3) @(negedge refclk);
      ale = 1'b0;
      repeat (4) @(negedge refclk);
    end else begin
      addr_in = 5'(a);
    end
    data_in = is_rd ? 8'h3C : d;
    cs_n = 1'b0;
    if (!sel_moto) begin
      if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
      repeat (12) begin
        @(negedge refclk);
        if (hs == 1'b0) low_cnt++;
      end
    end else begin
      rw = is_rd;
      @(negedge refclk);
      ds_n = 1'b0;
      for (int k = 0; k < 20 && low_cnt == 0; k++) begin
        @(negedge refclk);
        if (hs == 1'b0) low_cnt = 1;
      end
    end
    rv = data_out;
    last_oe = data_oe;
    rd_n = 1'b1; wr_n = 1'b1; ds_n = 1'b1; cs_n = 1'b1; rw = 1'b1;
    repeat (5) @(negedge refclk);
  endtask

  function automatic logic [7:0] pat(input int a, input int m);
    return 8'((a * 37 + m * 11 + 5) % 256);
  endfunction

  task automatic wr_chk(input int a, input logic [7:0] d);
    logic [7:0] rv;
    int lc;
    access(1'b0, a, d, rv, lc);
    model_wr(a, d);
    if (!sel_moto) chk((sel_demux && a == 10) ? "R7" : "R4", lc, (sel_demux && a == 10) ? 0 : WAIT_CYC);
    else           chk("R5", lc, 1);
  endtask

  task automatic rd_chk(input string req, input int a);
    logic [7:0] rv;
    int lc;
    access(1'b1, a, 8'h00, rv, lc);
    chk(req, rv, exp_q[a]);
    if (!sel_moto) begin
      chk("R4", lc, WAIT_CYC);
      chk("R4", last_oe, 1);
    end else begin
      chk("R5", lc, 1);
      chk("R5", last_oe, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge refclk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sel_demux = 1'b1; sel_moto = 1'b0;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ds_n = 1'b1; rw = 1'b1; ale = 1'b0;
    addr_in = '0; data_in = '0; alarm_in = '0; last_oe = 1'b0;
    for (int i = 0; i < 32; i++) exp_q[i] = 8'h00;
    repeat (4) @(negedge refclk);
    rst_n = 1'b1;
    repeat (5) @(negedge refclk);

    // R1 reset state
    chk("R1", hs, 1);
    chk("R1", irq_n, 1);
    chk("R1", data_oe, 0);
    for (int a = 0; a < 32; a++) rd_chk("R1", a);

    // mode sweep: bit1 = data-strobe style, bit0 = dedicated address bus
    for (int m = 0; m < 4; m++) begin
      sel_moto  = m[1];
      sel_demux = m[0];
      repeat (3) @(negedge refclk);
      for (int a = 0; a < 32; a++) if (a != 10) wr_chk(a, pat(a, m));
      for (int a = 0; a < 32; a++)
        rd_chk((a >= 18) ? "R8" : (a == 10) ? "R11" : sel_demux ? "R2" : "R3", a);
      wr_chk(10, pat(10, m));
      for (int a = 0; a < 18; a++) rd_chk("R11", a);
    end

    // R6: strobe without chip select
    sel_moto = 1'b0; sel_demux = 1'b1;
    wr_chk(3, 8'h11);
    addr_in = 5'd3; data_in = 8'h5A; wr_n = 1'b0;
    begin
      int hi_cnt;
      hi_cnt = 0;
      repeat (10) begin
        @(negedge refclk);
        if (hs == 1'b1) hi_cnt++;
      end
      chk("R6", hi_cnt, 10);
    end
    wr_n = 1'b1;
    repeat (5) @(negedge refclk);
    rd_chk("R6", 3);

    // R9 / R10 alarms
    wr_chk(10, 8'h00);
    alarm_in = 8'h04;
    repeat (2) @(negedge refclk);
    alarm_in = 8'h00;
    repeat (5) @(negedge refclk);
    exp_q[0] = 8'h04;
    rd_chk("R9", 0);
    chk("R10", irq_n, 1);
    wr_chk(1, 8'h04);
    repeat (3) @(negedge refclk);
    chk("R10", irq_n, 0);
    wr_chk(0, 8'h04);
    repeat (3) @(negedge refclk);
    rd_chk("R9", 0);
    chk("R10", irq_n, 1);
    alarm_in = 8'h01;
    repeat (5) @(negedge refclk);
    exp_q[0] = 8'h01;
    wr_chk(1, 8'h01);
    wr_chk(0, 8'h01);
    exp_q[0] = 8'h01;
    rd_chk("R9", 0);
    chk("R10", irq_n, 0);
    alarm_in = 8'h00;
    repeat (5) @(negedge refclk);
    wr_chk(0, 8'h01);
    rd_chk("R9", 0);
    repeat (3) @(negedge refclk);
    chk("R10", irq_n, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule